// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block is the software-visible register bank of a per-core interrupt controller. A simple single-register bus presents a byte offset, a write strobe and write data. The block decodes the offset into one of its registers, ignoring the three least significant offset bits. Each register then applies its own write rule: some keep only a field, one forces a field to ones, the version register cannot be written, and the local vector entries protect two status bits. Read data and the reserved-access error come out of registers one cycle after the access.

The error status register needs two writes to clear it. The first write only arms an internal flag. The second write drops the flag and zeroes the register. Reading the register cancels a pending arm. Bit 8 of a spurious-vector write drives an internal software-enable bit, which is brought out as a port together with the arm flag. Any offset that decodes to none of the implemented registers counts as reserved. This includes the in-service, request and trigger arrays, the command registers and the priority and end-of-interrupt offsets. A reserved access reads zero, changes nothing and raises the error output for one cycle.

Top module: `intc_regfile`

## Requirements
- R1: An offset is decoded with bits 2:0 ignored, so offset 0x24 reaches the identity register at 0x20 and 0x324 reaches vector entry 0 at 0x320, while 0x328 is reserved.
- R2: A write to the identity register (0x20) or the task priority register (0x80) stores only bits 7:0 and clears bits 31:8.
- R3: The version register (0x30) always reads the VERSION_VAL parameter, and writes to it have no effect.
- R4: A write to the logical destination register (0xD0) stores bits 31:24 and clears bits 23:0.
- R5: The destination format register (0xE0) resets to 0xFFFFFFFF. A write stores bits 31:28 as written and forces bits 27:0 to ones.
- R6: There are NUM_LVT vector entry registers at 0x320 + 0x10*i. A write to an entry stores every bit except bits 12 and 14, which keep their previous value (zero after reset).
- R7: Error status register (0x280): a write while the arm flag is clear sets the flag and leaves the register value unchanged. A write while the flag is set clears the flag and zeroes the register. The flag is visible on err_armed.
- R8: A read of the error status register clears the arm flag.
- R9: A write to the spurious vector register (0xF0) stores all 32 bits, and sw_enable takes the written bit 8 in the cycle after the write.
- R10: An access to a reserved offset reads 0, changes no register, and drives acc_err high for exactly the one cycle after the access. acc_err is low after any cycle with no reserved access.
- R11: After reset every register reads 0 except destination format (0xFFFFFFFF) and version (VERSION_VAL), and sw_enable, err_armed, acc_rdata and acc_err are 0.
- R12: acc_rdata takes the read value in the cycle after a read access and holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_off | input | OFF_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered |
| acc_err | output | 1 | Reserved-offset access, registered one-cycle pulse |
| sw_enable | output | 1 | Software-enable state taken from spurious vector bit 8 |
| err_armed | output | 1 | Error status arm flag |

## Verification
The bench goes after the offset boundaries. An unaligned offset inside a register must alias to that register, and an offset just past a vector entry must be reserved. A decoder that dropped too many low bits would turn 0x328 into an alias of entry 0 and let the reserved write corrupt it. The error status tests run the arm, clear and read-cancel sequences in turn. A design that zeroed the register on the first write, or that kept the arm flag across a read, shows a wrong err_armed level.

Writing all ones to every vector entry exposes any loss of the protected bits 12 and 14. Writes interleaved with reads show whether read data leaks or changes when no read occurs.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;

  localparam int unsigned DW = 32;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_VER,
    SEL_TPR,
    SEL_LDR,
    SEL_DFR,
    SEL_SVR,
    SEL_ESR,
    SEL_LVT
  } reg_sel_e;

  // field rules
  localparam logic [DW-1:0] LOW_BYTE_KEEP = 32'h0000_00FF;
  localparam logic [DW-1:0] LDR_KEEP      = 32'hFF00_0000;
  localparam logic [DW-1:0] DFR_FORCE     = 32'h0FFF_FFFF;
  localparam logic [DW-1:0] LVT_RO_MASK   = 32'h0000_5000;
  localparam int unsigned   SVR_EN_BIT    = 8;

endpackage

// File: rtl/intc_off_decode.sv
module intc_off_decode
  import intc_regs_pkg::*;
#(
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned NUM_LVT  = 6,
  parameter int unsigned LVT_BASE = 32'h320,
  parameter int unsigned LVT_STEP = 32'h10,
  localparam int unsigned LVT_IW  = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1
) (
  input  logic [OFF_W-1:0]  off,
  output reg_sel_e          sel,
  output logic [LVT_IW-1:0] lvt_idx
);

  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(7);

  logic [OFF_W-1:0] aligned;

  assign aligned = off & ALIGN_MASK;

  always_comb begin
    sel     = SEL_NONE;
    lvt_idx = '0;
    case (aligned)
      OFF_W'(32'h020): sel = SEL_ID;
      OFF_W'(32'h030): sel = SEL_VER;
      OFF_W'(32'h080): sel = SEL_TPR;
      OFF_W'(32'h0D0): sel = SEL_LDR;
      OFF_W'(32'h0E0): sel = SEL_DFR;
      OFF_W'(32'h0F0): sel = SEL_SVR;
      OFF_W'(32'h280): sel = SEL_ESR;
      default: begin
        for (int i = 0; i < NUM_LVT; i++) begin
          if (aligned == OFF_W'(LVT_BASE + i * LVT_STEP)) begin
            sel     = SEL_LVT;
            lvt_idx = LVT_IW'(i);
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/intc_lvt_bank.sv
module intc_lvt_bank
  import intc_regs_pkg::*;
#(
  parameter int unsigned NUM_LVT = 6,
  localparam int unsigned LVT_IW = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [LVT_IW-1:0]           wr_idx,
  input  logic [DW-1:0]               wr_data,
  output logic [NUM_LVT-1:0][DW-1:0]  entries
);

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_ent
    logic          we;
    logic [DW-1:0] ent_d;
    logic [DW-1:0] ent_q;

    always_comb begin
      we    = wr_en && (wr_idx == LVT_IW'(g));
      ent_d = ent_q;
      if (we) ent_d = (wr_data & ~LVT_RO_MASK) | (ent_q & LVT_RO_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= '0;
      else if (we) ent_q <= ent_d;
    end

    assign entries[g] = ent_q;

    // R6
    lvt_ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((ent_q & LVT_RO_MASK) == $past(ent_q & LVT_RO_MASK)));
  end

endmodule

// File: rtl/intc_err_status.sv
module intc_err_status
  import intc_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] esr_val,
  output logic          armed
);

  logic          arm_d, arm_q;
  logic [DW-1:0] esr_d, esr_q;
  logic          upd;

  always_comb begin
    arm_d = arm_q;
    esr_d = esr_q;
    if (wr) begin
      arm_d = ~arm_q;
      if (arm_q) esr_d = '0;
    end else if (rd) begin
      arm_d = 1'b0;
    end
    upd = wr || rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      esr_q <= '0;
    end else if (upd) begin
      arm_q <= arm_d;
      esr_q <= esr_d;
    end
  end

  assign esr_val = esr_q;
  assign armed   = arm_q;

  // R7
  esr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !armed) |=> (armed && $stable(esr_val)));

  // R7
  esr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && armed) |=> (!armed && esr_val == '0));

  // R8
  esr_rd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !armed);

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_regs_pkg::*;
#(
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned NUM_LVT     = 6,
  parameter int unsigned LVT_BASE    = 32'h320,
  parameter int unsigned LVT_STEP    = 32'h10,
  parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             acc_err,
  output logic             sw_enable,
  output logic             err_armed
);

  localparam int unsigned LVT_IW = (NUM_LVT > 1) ? $clog2(NUM_LVT) : 1;

  reg_sel_e                   sel;
  logic [LVT_IW-1:0]          lvt_idx;
  logic                       wr, rd;
  logic [NUM_LVT-1:0][DW-1:0] lvt_ents;
  logic [DW-1:0]              esr_val;
  logic [DW-1:0]              rd_val;

  logic [DW-1:0] id_d, id_q, tpr_d, tpr_q, ldr_d, ldr_q;
  logic [DW-1:0] dfr_d, dfr_q, svr_d, svr_q;
  logic          swen_d, swen_q;
  logic [DW-1:0] rdata_d, rdata_q;
  logic          err_d, err_q;
  logic          reg_ce;

  intc_off_decode #(
    .OFF_W   (OFF_W),
    .NUM_LVT (NUM_LVT),
    .LVT_BASE(LVT_BASE),
    .LVT_STEP(LVT_STEP)
  ) u_dec (
    .off    (acc_off),
    .sel    (sel),
    .lvt_idx(lvt_idx)
  );

  assign wr = acc_en && acc_we;
  assign rd = acc_en && !acc_we;

  intc_lvt_bank #(.NUM_LVT(NUM_LVT)) u_lvt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr && (sel == SEL_LVT)),
    .wr_idx (lvt_idx),
    .wr_data(acc_wdata),
    .entries(lvt_ents)
  );

  intc_err_status u_esr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr && (sel == SEL_ESR)),
    .rd     (rd && (sel == SEL_ESR)),
    .esr_val(esr_val),
    .armed  (err_armed)
  );

  // read selection
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_ID:  rd_val = id_q;
      SEL_VER: rd_val = VERSION_VAL;
      SEL_TPR: rd_val = tpr_q;
      SEL_LDR: rd_val = ldr_q;
      SEL_DFR: rd_val = dfr_q;
      SEL_SVR: rd_val = svr_q;
      SEL_ESR: rd_val = esr_val;
      SEL_LVT: begin
        for (int i = 0; i < NUM_LVT; i++)
          if (lvt_idx == LVT_IW'(i)) rd_val = lvt_ents[i];
      end
      default: rd_val = '0;
    endcase
  end

  // write policies and next state
  always_comb begin
    id_d    = id_q;
    tpr_d   = tpr_q;
    ldr_d   = ldr_q;
    dfr_d   = dfr_q;
    svr_d   = svr_q;
    swen_d  = swen_q;
    if (wr) begin
      case (sel)
        SEL_ID:  id_d  = acc_wdata & LOW_BYTE_KEEP;
        SEL_TPR: tpr_d = acc_wdata & LOW_BYTE_KEEP;
        SEL_LDR: ldr_d = acc_wdata & LDR_KEEP;
        SEL_DFR: dfr_d = acc_wdata | DFR_FORCE;
        SEL_SVR: begin
          svr_d  = acc_wdata;
          swen_d = acc_wdata[SVR_EN_BIT];
        end
        default: ;
      endcase
    end
    rdata_d = rd ? rd_val : rdata_q;
    err_d   = acc_en && (sel == SEL_NONE);
    reg_ce  = wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      tpr_q  <= '0;
      ldr_q  <= '0;
      dfr_q  <= '1;
      svr_q  <= '0;
      swen_q <= 1'b0;
    end else if (reg_ce) begin
      id_q   <= id_d;
      tpr_q  <= tpr_d;
      ldr_q  <= ldr_d;
      dfr_q  <= dfr_d;
      svr_q  <= svr_d;
      swen_q <= swen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign acc_rdata = rdata_q;
  assign acc_err   = err_q;
  assign sw_enable = swen_q;

  // R10
  rsv_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> (acc_rdata == '0));

  // R10
  err_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !acc_err);

  // R3
  ver_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_VER) |=> (acc_rdata == VERSION_VAL));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(acc_rdata));

  // R9
  swen_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_SVR) |=> (sw_enable == $past(acc_wdata[SVR_EN_BIT])));

  // R5
  dfr_low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_DFR) |=> (acc_rdata[27:0] == 28'hFFF_FFFF));

endmodule

// File: tb/tb_intc_regfile.sv
module tb_intc_regfile;

  localparam logic [31:0] VER = 32'h0005_0014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic [11:0] acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic        sw_enable;
  logic        err_armed;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] last_rd = '0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  intc_regfile #(.VERSION_VAL(VER)) dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_err(acc_err), .sw_enable(sw_enable), .err_armed(err_armed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expected result pushed into the scoreboard
  task automatic acc(input logic we, input logic [11:0] off, input logic [31:0] wd,
                     input logic [31:0] exp_rd, input logic exp_err, input string tag);
    exp_t it;
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_off = off; acc_wdata = wd;
    if (!we) last_rd = exp_rd;
    it.rd = last_rd; it.err = exp_err; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
    acc(1'b0, off, 32'h0, exp, 1'b0, tag);
  endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d, input string tag);
    acc(1'b1, off, d, 32'h0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      logic take;
      @(posedge clk);
      take = acc_en && rst_n;
      #1;
      if (take) begin
        exp_t it;
        it = sb.pop_front();
        chk({it.tag, " rdata"}, acc_rdata, it.rd);
        chk({it.tag, " err"}, {31'b0, acc_err}, {31'b0, it.err});
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata reset", acc_rdata, 32'h0);
    chk("R11 err reset", {31'b0, acc_err}, 32'h0);
    chk("R11 swen reset", {31'b0, sw_enable}, 32'h0);
    chk("R11 armed reset", {31'b0, err_armed}, 32'h0);
    rd(12'h020, 32'h0, "R11 id");
    rd(12'h030, VER, "R11 ver");
    rd(12'h080, 32'h0, "R11 tpr");
    rd(12'h0D0, 32'h0, "R11 ldr");
    rd(12'h0E0, 32'hFFFF_FFFF, "R11 dfr");
    rd(12'h0F0, 32'h0, "R11 svr");
    rd(12'h280, 32'h0, "R11 esr");
    for (int i = 0; i < 6; i++) rd(12'(12'h320 + 16 * i), 32'h0, "R11 lvt");

    // R2 and R1 aliasing
    wr(12'h020, 32'hABCD_1234, "R2 id wr");
    rd(12'h020, 32'h0000_0034, "R2 id");
    rd(12'h024, 32'h0000_0034, "R1 id alias 0x24");
    rd(12'h027, 32'h0000_0034, "R1 id alias 0x27");
    wr(12'h084, 32'hFFFF_FF5A, "R1 tpr wr alias");
    rd(12'h080, 32'h0000_005A, "R2 tpr");

    // R3 version read-only
    wr(12'h030, 32'h0, "R3 ver wr");
    rd(12'h030, VER, "R3 ver");

    // R4
    wr(12'h0D0, 32'h1234_5678, "R4 ldr wr");
    rd(12'h0D0, 32'h1200_0000, "R4 ldr");

    // R5
    wr(12'h0E0, 32'h5000_0000, "R5 dfr wr");
    rd(12'h0E0, 32'h5FFF_FFFF, "R5 dfr");
    wr(12'h0E0, 32'h0, "R5 dfr wr0");
    rd(12'h0E0, 32'h0FFF_FFFF, "R5 dfr zero");

    // R6 protected bits
    for (int i = 0; i < 6; i++) begin
      wr(12'(12'h320 + 16 * i), 32'hFFFF_FFFF, "R6 lvt wr ones");
      rd(12'(12'h324 + 16 * i), 32'hFFFF_AFFF, "R6 lvt ones");
      wr(12'(12'h320 + 16 * i), 32'h0001_5000 | i, "R6 lvt wr pattern");
      rd(12'(12'h320 + 16 * i), 32'h0001_0000 | i, "R6 lvt pattern");
    end

    // R9
    wr(12'h0F0, 32'h0000_01FF, "R9 svr wr");
    chk("R9 swen set", {31'b0, sw_enable}, 32'h1);
    rd(12'h0F0, 32'h0000_01FF, "R9 svr");
    wr(12'h0F0, 32'hA000_00FF, "R9 svr wr2");
    chk("R9 swen clr", {31'b0, sw_enable}, 32'h0);
    rd(12'h0F0, 32'hA000_00FF, "R9 svr2");

    // R7 handshake
    wr(12'h280, 32'hFFFF_FFFF, "R7 esr arm");
    chk("R7 armed after 1st", {31'b0, err_armed}, 32'h1);
    wr(12'h280, 32'hFFFF_FFFF, "R7 esr clear");
    chk("R7 disarmed after 2nd", {31'b0, err_armed}, 32'h0);
    rd(12'h280, 32'h0, "R7 esr value");
    // R8 read cancels arm
    wr(12'h280, 32'h1, "R8 esr arm");
    chk("R8 armed", {31'b0, err_armed}, 32'h1);
    rd(12'h280, 32'h0, "R8 esr read");
    chk("R8 disarmed by read", {31'b0, err_armed}, 32'h0);
    wr(12'h280, 32'h1, "R8 esr rearm");
    chk("R8 rearmed", {31'b0, err_armed}, 32'h1);

    // R10 reserved offsets
    acc(1'b0, 12'h040, 32'h0, 32'h0, 1'b1, "R10 rsv rd 0x40");
    acc(1'b1, 12'h328, 32'hDEAD_BEEF, 32'h0, 1'b1, "R10 rsv wr 0x328");
    rd(12'h320, 32'h0001_0000, "R10 lvt0 untouched");
    acc(1'b0, 12'h100, 32'h0, 32'h0, 1'b1, "R10 rsv rd 0x100");
    acc(1'b1, 12'h0B0, 32'h1, 32'h0, 1'b1, "R10 rsv wr 0xB0");
    acc(1'b0, 12'h3E0, 32'h0, 32'h0, 1'b1, "R10 rsv rd 0x3E0");
    @(negedge clk);
    chk("R10 err one cycle", {31'b0, acc_err}, 32'h0);

    // R12 hold across writes and idle
    rd(12'h0D0, 32'h1200_0000, "R12 ldr read");
    wr(12'h020, 32'h77, "R12 write keeps rdata");
    repeat (3) @(negedge clk);
    chk("R12 idle hold", acc_rdata, 32'h1200_0000);
    rd(12'h020, 32'h77, "R12 new read");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule